// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer. Its clock stands in for the oscillator signal that feeds the prescaler. Inside it sit three parts: a behavioural dual-modulus prescaler that divides by P or P+1, a swallow counter (A), and a main counter (N). Together they produce one output pulse every P*N+A input cycles. A single select input picks the base modulus P, either the low or the high value. With the default parameters these are 32 and 64. A narrow build with 8 and 16 and a 4-bit swallow counter is a matter of parameters only.

New A and N values arrive through a one-cycle write strobe. The mode input picks one of two update paths. In direct mode, a write lands in the active registers at once, and the counters pick it up when the current output period ends. In shadowed mode, a write is parked in a shadow pair. The copy into the active pair happens only at one point of the count: the start of the last prescaler period of an output period. A reload strobe marks that copy for neighbouring blocks, such as a reference counter. A second strobe follows exactly one output period later, for values that must change one period behind the counters, such as a charge-pump setting.

A standby input holds every counter at the start value of the programmed ratio. While in standby, writes take effect immediately. This means the first period after release is already the full, correct ratio.

Top module: `pswallow_divider`

## Requirements
- R1: While running, `div_out` is high for exactly one input cycle per output period, and consecutive pulses are P*N+A input cycles apart. P is the low modulus (32) when `mod_sel`=0 and the high modulus (64) when `mod_sel`=1.
- R2: Within each output period, `mod_ctl` is high for the first A prescaler periods and low for the rest. Across one steady period it is therefore high for A*(P+1) input cycles.
- R3: After `standby` is released, the first `div_out` pulse appears on the M-th rising edge that samples `standby` low, where M = P*N+A. No partial count from before standby carries over.
- R4: While `standby` is high, `div_out` stays low. A write during standby goes straight to the active values, whatever the mode.
- R5: With `sync_mode`=0, a write made before the last cycle of an output period leaves that period unchanged. The next period uses the new A and N.
- R6: With `sync_mode`=1, a write goes to the shadow pair. The shadow pair is copied to the active pair on the edge that starts the last prescaler period of the current output period. `reload_stb` is high in the cycle after that edge, and the new values rule from the next period. A write that arrives after that edge waits for the copy point of the following period.
- R7: `late_stb` pulses one cycle wide at the copy point of the output period that follows a shadow copy. That is one full new output period after `reload_stb`.
- R8: `mod_sel` is sampled only at an output-period boundary (or during standby). Changing it mid-period does not alter the current period.
- R9: A written N below 3 is used as 3.
- R10: After reset, all outputs are low and the active setting is A=0, N=3, low modulus. The first pulse therefore arrives on the 96th edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (prescaler input stand-in) |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Hold counters at start values, apply writes directly |
| sync_mode | input | 1 | 1: shadowed update at the copy point; 0: direct update |
| mod_sel | input | 1 | Base modulus select: 0 low, 1 high |
| wr_en | input | 1 | One-cycle write strobe for `wr_a`/`wr_n` |
| wr_a | input | AW (6) | New swallow count A |
| wr_n | input | NW (14) | New main count N |
| div_out | output | 1 | Divided output, one cycle per period |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| reload_stb | output | 1 | Shadow copy happened on the previous edge |
| late_stb | output | 1 | Copy point one output period after a shadow copy |

## Verification
The bench uses the default build: 14-bit N, 6-bit A, and base moduli 32 and 64. Keeping N between 3 and 20 in random trials holds each period to a few hundred or a thousand cycles. That lets many settings and both moduli run alongside the full 65-cycle prescaler period, the A equal to N corner, and the N floor. Directed sequences place writes both before and after the copy point of a period. They also change the modulus mid-period and release standby after direct writes. The narrow 8/16 build is not elaborated by the bench.

// File: rtl/pswd_pkg.sv
// Package: shared constants and types of the pulse-swallow divider.
// Assumes nothing beyond IEEE 1800-2017.
package pswd_pkg;

    // Smallest main count the divider accepts; lower writes are raised to it.
    localparam int unsigned N_FLOOR = 3;

    // Where an incoming A/N write is routed.
    typedef enum logic [1:0] {
        WR_NONE   = 2'd0,
        WR_DIRECT = 2'd1,
        WR_SHADOW = 2'd2
    } wr_path_e;

endpackage

// File: rtl/pswd_prescaler.sv
// Module: behavioural dual-modulus prescaler.
// Counts input cycles and raises tick on the last cycle of each prescaler
// period. The length of the next period (P or P+1) is taken from hi_nxt and
// swallow_nxt whenever the period restarts or while hold is high.
// Assumes P_LO >= 4 so that two ticks can never be adjacent.
module pswd_prescaler #(
    parameter int P_LO = 32,
    parameter int P_HI = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic hi_nxt,
    input  logic swallow_nxt,
    output logic tick
);
    localparam int CW = $clog2(P_HI + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_m1;

    // Length minus one of the prescaler period about to start.
    always_comb begin
        len_m1 = hi_nxt ? CW'(P_HI - 1) : CW'(P_LO - 1);
        if (swallow_nxt) begin
            len_m1 = len_m1 + 1'b1;
        end
    end

    assign tick = (cnt_q == '0);

    // Down-counter over one prescaler period; reloads on tick or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(P_LO - 1);
        end else if (hold || tick) begin
            cnt_q <= len_m1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R1: a prescaler period is never a single cycle.
    p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pswd_an_counter.sv
// Module: swallow (A) and main (N) counters with modulus latch.
// Advances once per prescaler tick. N counts the prescaler periods left in
// the output period; A counts the P+1 periods left. At the period end (tick
// with N at one) or during hold, both reload from the active values and the
// modulus select is sampled. Assumes n_load >= 3 and a_load <= n_load.
module pswd_an_counter #(
    parameter int NW = 14,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          tick,
    input  logic          mod_sel,
    input  logic [AW-1:0] a_load,
    input  logic [NW-1:0] n_load,
    output logic          period_end,
    output logic          zp1,
    output logic          swallow_nxt,
    output logic          hi_nxt,
    output logic          mod_ctl
);
    import pswd_pkg::*;

    logic [NW-1:0] n_q, n_d;
    logic [AW-1:0] a_q, a_d;
    logic          hi_q, hi_d;

    assign period_end = !hold && tick && (n_q == NW'(1));
    assign zp1        = !hold && tick && (n_q == NW'(2));

    // Next state of both counters and the latched modulus.
    always_comb begin
        n_d  = n_q;
        a_d  = a_q;
        hi_d = hi_q;
        if (hold || period_end) begin
            n_d  = n_load;
            a_d  = a_load;
            hi_d = mod_sel;
        end else if (tick) begin
            n_d = n_q - 1'b1;
            if (a_q != '0) begin
                a_d = a_q - 1'b1;
            end
        end
    end

    // Counter and modulus registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q  <= NW'(N_FLOOR);
            a_q  <= '0;
            hi_q <= 1'b0;
        end else begin
            n_q  <= n_d;
            a_q  <= a_d;
            hi_q <= hi_d;
        end
    end

    assign swallow_nxt = (a_d != '0);
    assign hi_nxt      = hi_d;
    assign mod_ctl     = (a_q != '0);

    // R1: the main count never sits at zero.
    p_ncnt_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
        n_q != '0);

    // R2: P+1 division only starts at a period boundary or from standby.
    p_modctl_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_ctl) |-> ($past(period_end) || $past(hold)));

    // R2: P+1 division ends only when a prescaler period ends.
    p_modctl_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_ctl) |-> ($past(tick) || $past(hold)));

endmodule

// File: rtl/pswd_prog_regs.sv
// Module: active and shadow A/N registers with transfer strobes.
// Direct writes (standby, or direct mode) land in the active pair. Shadowed
// writes park in the shadow pair until the next copy point (zp1). A copy arms
// a second strobe that fires at the following copy point.
// Assumes zp1 is high for one cycle at most per output period.
module pswd_prog_regs #(
    parameter int NW = 14,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          sync_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_a,
    input  logic [NW-1:0] wr_n,
    input  logic          zp1,
    output logic [AW-1:0] a_act,
    output logic [NW-1:0] n_act,
    output logic          reload_stb,
    output logic          late_stb
);
    import pswd_pkg::*;

    logic [AW-1:0] a_q, sh_a_q;
    logic [NW-1:0] n_q, sh_n_q;
    logic [NW-1:0] wr_n_c;
    logic          pend_q, arm_q, reload_q, late_q;
    wr_path_e      path;

    // Raise too-small main counts to the floor.
    assign wr_n_c = (wr_n < NW'(N_FLOOR)) ? NW'(N_FLOOR) : wr_n;

    // Route the write by mode and standby.
    always_comb begin
        if (!wr_en) begin
            path = WR_NONE;
        end else if (standby || !sync_mode) begin
            path = WR_DIRECT;
        end else begin
            path = WR_SHADOW;
        end
    end

    // Active/shadow storage, copy at the copy point, strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            n_q      <= NW'(N_FLOOR);
            sh_a_q   <= '0;
            sh_n_q   <= NW'(N_FLOOR);
            pend_q   <= 1'b0;
            arm_q    <= 1'b0;
            reload_q <= 1'b0;
            late_q   <= 1'b0;
        end else begin
            reload_q <= 1'b0;
            late_q   <= 1'b0;
            if (standby) begin
                if (path == WR_DIRECT) begin
                    a_q <= wr_a;
                    n_q <= wr_n_c;
                end else if (pend_q) begin
                    a_q <= sh_a_q;
                    n_q <= sh_n_q;
                end
                pend_q <= 1'b0;
                arm_q  <= 1'b0;
            end else begin
                if (zp1 && arm_q) begin
                    late_q <= 1'b1;
                    arm_q  <= 1'b0;
                end
                if (zp1 && sync_mode && pend_q) begin
                    a_q      <= sh_a_q;
                    n_q      <= sh_n_q;
                    pend_q   <= 1'b0;
                    reload_q <= 1'b1;
                    arm_q    <= 1'b1;
                end
                case (path)
                    WR_DIRECT: begin
                        a_q <= wr_a;
                        n_q <= wr_n_c;
                    end
                    WR_SHADOW: begin
                        sh_a_q <= wr_a;
                        sh_n_q <= wr_n_c;
                        pend_q <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign a_act      = a_q;
    assign n_act      = n_q;
    assign reload_stb = reload_q;
    assign late_stb   = late_q;

    // R6: a pending shadow transfer is only ever created by a write.
    p_pend_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(wr_en));

    // R6: the reload strobe follows a running cycle in shadowed mode.
    p_reload_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |-> ($past(sync_mode) && !$past(standby)));

    // R9: the active main count never drops below the floor.
    p_nfloor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        n_act >= NW'(N_FLOOR));

endmodule

// File: rtl/pswallow_divider.sv
// Module: pulse-swallow dual-modulus feedback divider (top).
// Divides the input clock by P*N+A using a behavioural P/(P+1) prescaler,
// a swallow counter and a main counter. New A/N values are routed directly
// or through shadow registers copied at the last prescaler period.
// Assumes A <= N and N >= 3 for the stated ratio.
module pswallow_divider #(
    parameter int NW   = 14,
    parameter int AW   = 6,
    parameter int P_LO = 32,
    parameter int P_HI = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby,
    input  logic          sync_mode,
    input  logic          mod_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_a,
    input  logic [NW-1:0] wr_n,
    output logic          div_out,
    output logic          mod_ctl,
    output logic          reload_stb,
    output logic          late_stb
);
    logic [AW-1:0] a_act;
    logic [NW-1:0] n_act;
    logic          tick, period_end, zp1, swallow_nxt, hi_nxt;
    logic          div_q;

    pswd_prog_regs #(.NW(NW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .sync_mode  (sync_mode),
        .wr_en      (wr_en),
        .wr_a       (wr_a),
        .wr_n       (wr_n),
        .zp1        (zp1),
        .a_act      (a_act),
        .n_act      (n_act),
        .reload_stb (reload_stb),
        .late_stb   (late_stb)
    );

    pswd_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_psc (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (standby),
        .hi_nxt      (hi_nxt),
        .swallow_nxt (swallow_nxt),
        .tick        (tick)
    );

    pswd_an_counter #(.NW(NW), .AW(AW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (standby),
        .tick        (tick),
        .mod_sel     (mod_sel),
        .a_load      (a_act),
        .n_load      (n_act),
        .period_end  (period_end),
        .zp1         (zp1),
        .swallow_nxt (swallow_nxt),
        .hi_nxt      (hi_nxt),
        .mod_ctl     (mod_ctl)
    );

    // Register the period end into a clean one-cycle output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else begin
            div_q <= period_end;
        end
    end

    assign div_out = div_q;

    // R1: the output pulse is one input cycle wide.
    p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R4: no output pulse follows a standby cycle.
    p_standby_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !div_out);

endmodule

// File: tb/sim_pswallow_divider.sv
module sim_pswallow_divider;
    localparam int NW   = 14;
    localparam int AW   = 6;
    localparam int P_LO = 32;
    localparam int P_HI = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0;
    logic          sync_mode = 1'b0;
    logic          mod_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_a = '0;
    logic [NW-1:0] wr_n = NW'(3);
    logic          div_out, mod_ctl, reload_stb, late_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pswallow_divider #(.NW(NW), .AW(AW), .P_LO(P_LO), .P_HI(P_HI)) u0 (
        .clk(clk), .rst_n(rst_n), .standby(standby), .sync_mode(sync_mode),
        .mod_sel(mod_sel), .wr_en(wr_en), .wr_a(wr_a), .wr_n(wr_n),
        .div_out(div_out), .mod_ctl(mod_ctl), .reload_stb(reload_stb),
        .late_stb(late_stb)
    );

    function automatic int pval(bit s);
        return s ? P_HI : P_LO;
    endfunction

    function automatic int nfix(int n);
        return (n < 3) ? 3 : n;
    endfunction

    function automatic int ratio(int a, int n, bit s);
        return pval(s) * nfix(n) + a;
    endfunction

    function automatic int last_len(int a, int n, bit s);
        return (a >= nfix(n)) ? pval(s) + 1 : pval(s);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_an(int a, int n);
        wr_a  = AW'(a);
        wr_n  = NW'(n);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count negedges until div_out is seen; record strobe positions.
    task automatic wait_pulse(output int n, output int hi, output int rl, output int lt);
        n = 0; hi = 0; rl = 0; lt = 0;
        do begin
            @(negedge clk);
            n++;
            if (mod_ctl)    hi++;
            if (reload_stb) rl = n;
            if (late_stb)   lt = n;
        end while (!div_out && n < 20000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, hi, rl, lt, n1, rl1, quiet, rlc;
        void'($urandom(32'h5A17));

        // R10: reset state
        repeat (4) @(negedge clk);
        chk("R10 div_out in reset", int'(div_out), 0);
        chk("R10 reload_stb in reset", int'(reload_stb), 0);
        chk("R10 late_stb in reset", int'(late_stb), 0);
        rst_n = 1'b1;
        wait_pulse(n, hi, rl, lt);
        chk("R10 first period after reset", n, 96);
        wait_pulse(n, hi, rl, lt);
        chk("R1 default period", n, 96);

        // R4, R9: standby write with N below floor, high modulus
        standby = 1'b1;
        @(negedge clk);
        write_an(0, 1);
        mod_sel = 1'b1;
        quiet = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (div_out) quiet++;
        end
        chk("R4 no pulse in standby", quiet, 0);
        standby = 1'b0;
        wait_pulse(n, hi, rl, lt);
        chk("R9 N floor, first period", n, ratio(0, 1, 1'b1));

        // R1, R2, R3: random settings from standby
        for (int t = 0; t < 10; t++) begin
            int rn, ra;
            bit rs;
            rs = 1'($urandom % 2);
            rn = 3 + int'($urandom % 18);
            ra = int'($urandom % (rn + 1));
            if (t == 0) begin rn = 7; ra = 7; rs = 1'b1; end
            if (t == 1) begin rn = 3; ra = 0; rs = 1'b0; end
            standby = 1'b1;
            mod_sel = rs;
            @(negedge clk);
            write_an(ra, rn);
            repeat (2) @(negedge clk);
            standby = 1'b0;
            wait_pulse(n, hi, rl, lt);
            chk("R3 first period after release", n, ratio(ra, rn, rs));
            wait_pulse(n, hi, rl, lt);
            chk("R1 steady period", n, ratio(ra, rn, rs));
            chk("R2 mod_ctl high cycles", hi, ra * (pval(rs) + 1));
        end

        // R5: direct write mid-period
        standby = 1'b1;
        mod_sel = 1'b0;
        @(negedge clk);
        write_an(5, 10);
        repeat (2) @(negedge clk);
        standby = 1'b0;
        wait_pulse(n, hi, rl, lt);
        write_an(9, 12);
        wait_pulse(n, hi, rl, lt);
        chk("R5 current period unchanged", n, ratio(5, 10, 1'b0) - 1);
        wait_pulse(n, hi, rl, lt);
        chk("R5 next period uses new A/N", n, ratio(9, 12, 1'b0));

        // R8: modulus change mid-period
        mod_sel = 1'b1;
        wait_pulse(n, hi, rl, lt);
        chk("R8 current period keeps modulus", n, ratio(9, 12, 1'b0));
        wait_pulse(n, hi, rl, lt);
        chk("R8 next period new modulus", n, ratio(9, 12, 1'b1));

        // R6, R7: shadowed write early in the period
        sync_mode = 1'b1;
        write_an(4, 6);
        wait_pulse(n1, hi, rl1, lt);
        chk("R6 old period kept", n1, ratio(9, 12, 1'b1) - 1);
        chk("R6 reload strobe seen", int'(rl1 > 0), 1);
        chk("R6 copy at last prescaler period", n1 - rl1, last_len(9, 12, 1'b1));
        wait_pulse(n, hi, rl, lt);
        chk("R6 new values after copy", n, ratio(4, 6, 1'b1));
        chk("R7 late strobe distance", (n1 - rl1) + lt,
            last_len(9, 12, 1'b1) + ratio(4, 6, 1'b1) - last_len(4, 6, 1'b1));

        // R6: shadowed write after the copy point waits one more period
        rlc = 0;
        for (int i = 0; i < 329; i++) begin
            @(negedge clk);
            if (reload_stb) rlc++;
        end
        write_an(7, 8);
        wait_pulse(n, hi, rl, lt);
        chk("R6 late write: period tail", n, ratio(4, 6, 1'b1) - 330);
        chk("R6 late write: no copy this period", rlc + rl, 0);
        wait_pulse(n1, hi, rl1, lt);
        chk("R6 late write: old values one more period", n1, ratio(4, 6, 1'b1));
        chk("R6 late write: copy strobe", n1 - rl1, last_len(4, 6, 1'b1));
        wait_pulse(n, hi, rl, lt);
        chk("R6 late write: applied", n, ratio(7, 8, 1'b1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule